// File: doc/BRIEF.md
# Lease-Timestamp Coherence Controller for a Shared Cache Bank

This block keeps the tags and lease timestamps of one shared cache bank. Private first-level caches may keep a copy of a line only until an absolute point in global time, the lease expiry. Because each copy expires by itself, the bank never sends invalidations, recalls or acknowledgements. A line whose timestamp is below the current global time has no valid private copies.

Requests arrive on one valid/ready channel. Each request carries an opcode, an address, a requested lifetime and write data. A load pushes the line's lease out to cover the lifetime it asks for, and it returns the data together with the expiry. A store writes at once, even while other copies are still live. It returns a global write completion time: the moment after which no stale copy of the line can remain. The core uses that value to order a later fence. The array is direct-mapped. A miss installs the line in the same cycle. Fetching fill data from external memory is outside this block, so a freshly installed line reads as zero.

Top module: `lease_l2_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after its release, `rsp_valid` is 0. From the first cycle after release, `req_ready` is 1. Every line starts invalid.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Its response is presented, with `rsp_valid` at 1, in the very next cycle. `rsp_valid` is 0 in every other cycle.
- R3: The address splits into a set index in the low log2(SETS) bits and a tag in the remaining upper bits. A request hits when the indexed line is valid and its tag matches.
- R4: A load hit (`req_op` = 0) sets the line timestamp to the larger of its old value and `gtime + req_life`. It returns that value on `rsp_ts` and the line data on `rsp_data`.
- R5: A load whose `gtime + req_life` is below the line's current timestamp leaves the timestamp unchanged. The response returns the old, longer expiry.
- R6: A load miss installs the new tag with data zero and timestamp `gtime + req_life`. Any previous line in that set is dropped together with its timestamp.
- R7: A store hit (`req_op` = 1) to an unexpired line (timestamp >= `gtime`) writes `req_wdata` immediately, leaves the timestamp unchanged, and returns that timestamp as its completion time.
- R8: A store hit to an expired line (timestamp < `gtime`) writes the data and returns `gtime` as its completion time.
- R9: A store miss installs the line with `req_wdata` and timestamp `gtime`. It returns `gtime` as its completion time. A store response echoes `req_wdata` on `rsp_data`.
- R10: A load returns the data of the most recent store to the same address, provided that no eviction has happened in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gtime | input | 32 | Shared global time |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 1 | 0 = load, 1 = store |
| req_addr | input | 12 | Line address |
| req_life | input | 16 | Requested lease lifetime (loads) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Line data after the access |
| rsp_ts | output | 32 | Lease expiry (load) or write completion time (store) |

## Verification
The evict-and-install path and the lease or completion-time computation fall in the same cycle. When a conflicting request replaces a line whose lease is still running, the new timestamp must come from global time and not from the victim's expiry. Directed sequences provoke this by loading one tag with a long lease and then sending a store and a load with another tag to the same set. The random phase also provokes it, by drawing addresses from a small pool of tags over few sets. Each response is judged against a bench model that applies the requirement formulas to its own copy of tags, timestamps and data.

// File: rtl/lease_pkg.sv
package lease_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } lease_op_e;
endpackage

// File: rtl/lease_tag_array.sv
module lease_tag_array #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 8,
  parameter int TS_W   = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [TS_W-1:0]   rd_ts,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [TS_W-1:0]   wr_ts,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   line_vld;
  logic [TAG_W-1:0]  line_tag  [SETS];
  logic [TS_W-1:0]   line_ts   [SETS];
  logic [DATA_W-1:0] line_data [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_line
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   line_vld[s] <= 1'b0;
      else if (sel) line_vld[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        line_tag[s]  <= wr_tag;
        line_ts[s]   <= wr_ts;
        line_data[s] <= wr_data;
      end
    end
  end

  assign rd_valid = line_vld[rd_idx];
  assign rd_tag   = line_tag[rd_idx];
  assign rd_ts    = line_ts[rd_idx];
  assign rd_data  = line_data[rd_idx];
endmodule

// File: rtl/lease_calc.sv
module lease_calc import lease_pkg::*; #(
  parameter int TS_W   = 32,
  parameter int LIFE_W = 16,
  parameter int DATA_W = 32
) (
  input  lease_op_e         op,
  input  logic              hit,
  input  logic [TS_W-1:0]   gtime,
  input  logic [LIFE_W-1:0] life,
  input  logic [TS_W-1:0]   old_ts,
  input  logic [DATA_W-1:0] old_data,
  input  logic [DATA_W-1:0] wdata,
  output logic [TS_W-1:0]   new_ts,
  output logic [DATA_W-1:0] new_data,
  output logic [TS_W-1:0]   rsp_ts,
  output logic [DATA_W-1:0] rsp_data
);
  logic [TS_W-1:0] base_ts;
  logic [TS_W-1:0] want_ts;

  always_comb begin
    base_ts = hit ? old_ts : gtime;
    want_ts = gtime + TS_W'(life);
    if (op == OP_LOAD) begin
      new_ts   = (want_ts > base_ts) ? want_ts : base_ts;
      new_data = hit ? old_data : '0;
      rsp_ts   = new_ts;
    end else begin
      new_ts   = base_ts;
      new_data = wdata;
      rsp_ts   = (base_ts < gtime) ? gtime : base_ts;
    end
    rsp_data = new_data;
  end
endmodule

// File: rtl/lease_l2_ctrl.sv
module lease_l2_ctrl import lease_pkg::*; #(
  parameter int SETS   = 16,
  parameter int ADDR_W = 12,
  parameter int TS_W   = 32,
  parameter int LIFE_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   gtime,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LIFE_W-1:0] req_life,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TS_W-1:0]   rsp_ts
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              ready_q;
  logic              accept;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [TS_W-1:0]   rd_ts;
  logic [DATA_W-1:0] rd_data;
  logic              hit;
  logic [TS_W-1:0]   nx_line_ts;
  logic [DATA_W-1:0] nx_line_data;
  logic [TS_W-1:0]   nx_rsp_ts;
  logic [DATA_W-1:0] nx_rsp_data;
  logic              rsp_valid_q;
  logic [TS_W-1:0]   rsp_ts_q;
  logic [DATA_W-1:0] rsp_data_q;
  lease_op_e         op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q;
  assign idx       = req_addr[IDX_W-1:0];
  assign tag       = req_addr[ADDR_W-1:IDX_W];
  assign op        = lease_op_e'(req_op);
  assign hit       = rd_valid && (rd_tag == tag);

  lease_tag_array #(
    .SETS(SETS), .TAG_W(TAG_W), .TS_W(TS_W), .DATA_W(DATA_W)
  ) tags_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_ts(rd_ts), .rd_data(rd_data),
    .wr_en(accept), .wr_idx(idx), .wr_tag(tag),
    .wr_ts(nx_line_ts), .wr_data(nx_line_data)
  );

  lease_calc #(
    .TS_W(TS_W), .LIFE_W(LIFE_W), .DATA_W(DATA_W)
  ) calc_i (
    .op(op), .hit(hit), .gtime(gtime), .life(req_life),
    .old_ts(rd_ts), .old_data(rd_data), .wdata(req_wdata),
    .new_ts(nx_line_ts), .new_data(nx_line_data),
    .rsp_ts(nx_rsp_ts), .rsp_data(nx_rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= accept;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rsp_ts_q   <= nx_rsp_ts;
      rsp_data_q <= nx_rsp_data;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ts    = rsp_ts_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/lease_l2_ctrl_chk.sv
module lease_l2_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int TS_W   = 32,
  parameter int LIFE_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TS_W-1:0]   gtime,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LIFE_W-1:0] req_life,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic [TS_W-1:0]   rsp_ts
);
  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready)) |=> !rsp_valid);

  a_r4_load_lease_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_op)
      |=> rsp_ts >= $past(gtime) + {{(TS_W-LIFE_W){1'b0}}, $past(req_life)});

  a_r8_gwct_not_in_past: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op) |=> rsp_ts >= $past(gtime));

  a_r9_store_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op) |=> rsp_data == $past(req_wdata));
endmodule

bind lease_l2_ctrl lease_l2_ctrl_chk #(
  .ADDR_W(ADDR_W), .TS_W(TS_W), .LIFE_W(LIFE_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .gtime(gtime),
  .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .req_addr(req_addr), .req_life(req_life), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ts(rsp_ts)
);

// File: tb/lease_l2_ctrl_tb_top.sv
`timescale 1ns/1ps
module lease_l2_ctrl_tb_top;
  localparam int SETS = 16;
  localparam int IDXW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] gtime = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [11:0] req_addr = '0;
  logic [15:0] req_life = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] rsp_ts;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        m_vld  [SETS];
  logic [7:0]  m_tag  [SETS];
  logic [31:0] m_ts   [SETS];
  logic [31:0] m_data [SETS];

  always #2 clk = ~clk;

  lease_l2_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .gtime(gtime),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_life(req_life), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ts(rsp_ts)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] max32(logic [31:0] a, logic [31:0] b);
    return (a > b) ? a : b;
  endfunction

  task automatic do_req(bit op, logic [11:0] addr, logic [15:0] life,
                        logic [31:0] wd, logic [31:0] gt);
    int i = int'(addr[IDXW-1:0]);
    logic [7:0] t = addr[11:IDXW];
    bit h = m_vld[i] && (m_tag[i] == t);
    logic [31:0] ets, edat;
    string tg;
    if (!op) begin
      if (h) begin
        ets  = max32(m_ts[i], gt + 32'(life));
        edat = m_data[i];
        tg   = (gt + 32'(life) < m_ts[i]) ? "R5" : "R4";
        if (tg == "R4") tg = "R10_R4";
      end else begin
        ets  = gt + 32'(life);
        edat = '0;
        tg   = "R6";
      end
      m_ts[i] = ets;
      m_data[i] = edat;
    end else begin
      edat = wd;
      if (h && m_ts[i] >= gt) begin ets = m_ts[i]; tg = "R7"; end
      else if (h)             begin ets = gt; m_ts[i] = gt; tg = "R8"; end
      else                    begin ets = gt; m_ts[i] = gt; tg = "R9"; end
      m_data[i] = wd;
    end
    m_vld[i] = 1'b1;
    m_tag[i] = t;
    @(negedge clk);
    gtime = gt; req_op = op; req_addr = addr; req_life = life;
    req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", {31'b0, rsp_valid}, 32'd1);
    check(tg, rsp_ts, ets);
    check(tg, rsp_data, edat);
    @(negedge clk);
    check("R2", {31'b0, rsp_valid}, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] gt;
    void'($urandom(32'd20240607));
    for (int s = 0; s < SETS; s++) m_vld[s] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'b0, rsp_valid}, 32'd0);
    check("R1", {31'b0, req_ready}, 32'd1);

    // R6: load miss on fresh line reads zero, lease = gtime + life
    do_req(1'b0, 12'h015, 16'd50, 32'h0, 32'd100);
    // R5: shorter request does not shorten lease
    do_req(1'b0, 12'h015, 16'd5, 32'h0, 32'd110);
    // R4: longer request extends
    do_req(1'b0, 12'h015, 16'd80, 32'h0, 32'd120);
    // R7: store to unexpired line, completion = line timestamp
    do_req(1'b1, 12'h015, 16'd0, 32'hCAFE0001, 32'd130);
    // R10: load sees the store
    do_req(1'b0, 12'h015, 16'd1, 32'h0, 32'd140);
    // R8: store after expiry returns gtime
    do_req(1'b1, 12'h015, 16'd0, 32'hBEEF0002, 32'd500);
    // R3/R6: conflicting tag in same set evicts live line
    do_req(1'b0, 12'h023, 16'd200, 32'h0, 32'd510);
    do_req(1'b1, 12'h033, 16'd0, 32'h12345678, 32'd520);
    do_req(1'b0, 12'h023, 16'd3, 32'h0, 32'd530);
    // R9: store miss on empty set
    do_req(1'b1, 12'h0A7, 16'd0, 32'h0BADF00D, 32'd540);

    gt = 32'd1000;
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      gt += 32'($urandom % 8);
      a = {6'b0, 2'($urandom % 3), 4'($urandom % 4)};
      do_req(1'($urandom % 2), a, 16'($urandom % 64), $urandom, gt);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule